// File: doc/BRIEF.md
# LED-Count Delayed Output Gate

This block takes one serial LED data stream and drives two copies of it. The direct copy follows the input at all times. The delayed copy is held low until a selected number of whole LEDs has gone by since the last line reset, where one LED is a group of 24 data bits. After that point the delayed copy carries the stream too. The resulting effect is that a second LED chain receives the same frame, shifted by that many LEDs.

The delay comes from a 5-bit strap value, so 0 to 31 LEDs can be chosen. An idle detector outside the block supplies two signals. The first is a one-cycle pulse that restarts the bit and LED counters. The second is an active-low level that clears the output enable while the line is idle. A strap value of zero makes the block a plain two-way splitter. The data input must already be synchronized to `clk`.

Top module: `led_gate`

## Requirements
- R1: `directOut` equals `dataIn` at all times.
- R2: A 0-to-1 transition of `dataIn`, as sampled on `clk`, counts as one data bit. The LED count goes up by one after every 24th counted bit.
- R3: While `lineRstN` is low, and in the cycle after `idlePulse` is high, the bit count and the LED count are both zero.
- R4: The enable sets only on a clock edge where `dataIn` is low and the registered match is true. As a result, the bit that completes the matching LED never appears on `delayedOut`, and the bit after it does.
- R5: Once set, the enable stays set until `lineRstN` goes low. An `idlePulse` alone does not clear it.
- R6: `delayedOut` is high only while `dataIn` is high and the enable is set.
- R7: While `lineRstN` is low and `delayStrap` is 0, the enable is set, so every bit after the line reset passes on `delayedOut`.
- R8: The LED count stops at 31 and does not wrap. A strap value that is lowered below the count mid-frame therefore never matches within that frame.
- R9: An `idlePulse` in the middle of a frame drops the bits counted before it. The delay is then counted again from the pulse.
- R10: With strap value N from 1 to 31, after a line reset the first 24*N bits are blocked on `delayedOut` and every later bit passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low chip reset |
| dataIn | input | 1 | Synchronized serial LED data |
| idlePulse | input | 1 | One-cycle restart of the bit and LED counts |
| lineRstN | input | 1 | Active-low idle level; clears or presets the enable |
| delayStrap | input | 5 | Delay in whole LEDs (0 to 31) |
| directOut | output | 1 | Undelayed copy of `dataIn` |
| delayedOut | output | 1 | `dataIn` gated by the enable |

## Verification
The stream is tried with strap values 0, 1, 3 and 31 after a line reset. These runs separate an immediate pass, a one-LED offset, a multi-LED offset and the largest delay, and each shows exactly which bit is the first to pass. A second frame runs without a new line reset, to show that the enable persists and that a later line reset clears it again. An `idlePulse` sent partway through a group shows that the partial count is discarded. In one frame the strap is lowered after the count has passed the new value, and the stream then runs well beyond 32 LEDs. This case separates a counter that saturates from one that wraps around and matches late.

// File: rtl/led_gate_pkg.sv
package led_gate_pkg;
  // Strobes sent by the control to the datapath each cycle.
  typedef struct packed {
    logic bitRise;    // a data bit started this cycle
    logic groupDone;  // this bit completes a whole LED group
    logic clearCnt;   // restart the LED count
  } gateStrobes_t;
endpackage

// File: rtl/led_gate_ctrl.sv
module led_gate_ctrl
  import led_gate_pkg::*;
#(
  parameter int BITS_PER_LED = 24
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         dataIn,
  input  logic         idlePulse,
  input  logic         lineRstN,
  output gateStrobes_t strobes
);
  localparam int BIT_W = $clog2(BITS_PER_LED);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS_PER_LED - 1);

  logic             dataPrev;
  logic [BIT_W-1:0] bitCnt;
  logic             clearNow;
  logic             riseNow;

  assign clearNow = idlePulse || !lineRstN;
  assign riseNow  = dataIn && !dataPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataPrev <= 1'b0;
    end else begin
      dataPrev <= dataIn;
    end
  end

  // Position of the next bit within the current LED group.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (clearNow) begin
      bitCnt <= '0;
    end else if (riseNow) begin
      if (bitCnt == LAST_BIT) bitCnt <= '0;
      else                    bitCnt <= bitCnt + BIT_W'(1);
    end
  end

  always_comb begin
    strobes.clearCnt  = clearNow;
    strobes.bitRise   = riseNow && !clearNow;
    strobes.groupDone = riseNow && !clearNow && (bitCnt == LAST_BIT);
  end
endmodule

// File: rtl/led_gate_dp.sv
module led_gate_dp
  import led_gate_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataIn,
  input  logic             lineRstN,
  input  logic [CNT_W-1:0] delayStrap,
  input  gateStrobes_t     strobes,
  output logic [CNT_W-1:0] ledCnt,
  output logic             enable,
  output logic             delayedOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic matchQ;

  // Number of completed LED groups, held at the maximum.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledCnt <= '0;
    end else if (strobes.clearCnt) begin
      ledCnt <= '0;
    end else if (strobes.groupDone && (ledCnt != CNT_MAX)) begin
      ledCnt <= ledCnt + CNT_W'(1);
    end
  end

  // Registered compare so that counter transitions cannot glitch the latch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchQ <= 1'b0;
    else       matchQ <= (ledCnt == delayStrap);
  end

  // Enable latch: preset for a zero strap while idle, armed only with data low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
    end else if (!lineRstN) begin
      enable <= (delayStrap == '0);
    end else if (!dataIn && matchQ) begin
      enable <= 1'b1;
    end
  end

  assign delayedOut = dataIn && enable;
endmodule

// File: rtl/led_gate.sv
module led_gate
  import led_gate_pkg::*;
#(
  parameter int BITS_PER_LED = 24,
  parameter int CNT_W        = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataIn,
  input  logic             idlePulse,
  input  logic             lineRstN,
  input  logic [CNT_W-1:0] delayStrap,
  output logic             directOut,
  output logic             delayedOut
);
  gateStrobes_t     strobes;
  logic [CNT_W-1:0] ledCnt;
  logic             enable;

  led_gate_ctrl #(.BITS_PER_LED(BITS_PER_LED)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dataIn    (dataIn),
    .idlePulse (idlePulse),
    .lineRstN  (lineRstN),
    .strobes   (strobes)
  );

  led_gate_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dataIn     (dataIn),
    .lineRstN   (lineRstN),
    .delayStrap (delayStrap),
    .strobes    (strobes),
    .ledCnt     (ledCnt),
    .enable     (enable),
    .delayedOut (delayedOut)
  );

  assign directOut = dataIn;
endmodule

// File: rtl/led_gate_chk.sv
module led_gate_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             dataIn,
  input logic             idlePulse,
  input logic             lineRstN,
  input logic [CNT_W-1:0] delayStrap,
  input logic             directOut,
  input logic             delayedOut,
  input logic [CNT_W-1:0] ledCnt,
  input logic             enable
);
  p_direct_r1: assert property (@(posedge clk) disable iff (!rstN)
    directOut == dataIn);

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (idlePulse || !lineRstN) |=> (ledCnt == '0));

  p_arm_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(enable) && $past(lineRstN)) |-> !$past(dataIn));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && lineRstN) |=> enable);

  p_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    delayedOut |-> (dataIn && enable));

  p_zero_preset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!lineRstN && (delayStrap == '0)) |=> enable);

  p_saturate_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((ledCnt == {CNT_W{1'b1}}) && lineRstN && !idlePulse) |=> (ledCnt == {CNT_W{1'b1}}));
endmodule

bind led_gate led_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dataIn     (dataIn),
  .idlePulse  (idlePulse),
  .lineRstN   (lineRstN),
  .delayStrap (delayStrap),
  .directOut  (directOut),
  .delayedOut (delayedOut),
  .ledCnt     (ledCnt),
  .enable     (enable)
);

// File: tb/test_led_gate.sv
module test_led_gate;
  logic       clk = 1'b0;
  logic       rstN;
  logic       dataIn;
  logic       idlePulse;
  logic       lineRstN;
  logic [4:0] delayStrap;
  logic       directOut;
  logic       delayedOut;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;
  bit  expQ[$];
  string tagQ[$];

  // Reference model state, built from the requirements.
  int  bitsM = 0;
  int  grpM  = 0;
  bit  enM   = 0;

  always #10 clk = ~clk;

  led_gate i_led_gate (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .idlePulse(idlePulse),
    .lineRstN(lineRstN), .delayStrap(delayStrap),
    .directOut(directOut), .delayedOut(delayedOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: predicts the delayed output for one bit and sends it.
  task automatic sendBit(input string tag);
    if (grpM == int'(delayStrap)) enM = 1;
    expQ.push_back(enM);
    tagQ.push_back(tag);
    dataIn = 1'b1;
    repeat (3) @(negedge clk);
    dataIn = 1'b0;
    repeat (2) begin
      @(negedge clk);
      check(delayedOut == 1'b0, "R6 low phase", delayedOut, 0);
    end
    @(negedge clk);
    bitsM++;
    if (bitsM == 24) begin
      bitsM = 0;
      if (grpM < 31) grpM++;
    end
  endtask

  task automatic sendBits(input int n, input string tag);
    for (int i = 0; i < n; i++) sendBit(tag);
  endtask

  // Line reset: the idle pulse and the low level arrive together (R3, R7).
  task automatic lineReset(input logic [4:0] strap);
    delayStrap = strap;
    idlePulse  = 1'b1;
    lineRstN   = 1'b0;
    @(negedge clk);
    idlePulse  = 1'b0;
    repeat (3) @(negedge clk);
    lineRstN   = 1'b1;
    @(negedge clk);
    bitsM = 0;
    grpM  = 0;
    enM   = (strap == 0);
  endtask

  // Idle pulse on its own: clears counts, keeps enable (R9, R5).
  task automatic idleOnly();
    idlePulse = 1'b1;
    @(negedge clk);
    idlePulse = 1'b0;
    @(negedge clk);
    bitsM = 0;
    grpM  = 0;
  endtask

  // Monitor: one sample in the middle of each high phase.
  initial begin
    forever begin
      @(posedge dataIn);
      @(negedge clk);
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected bit", delayedOut, 0);
      end else begin
        bit    e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(delayedOut == e, t, delayedOut, e);
        check(directOut == 1'b1, "R1 direct high", directOut, 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; dataIn = 1'b0; idlePulse = 1'b0; lineRstN = 1'b0; delayStrap = 5'd0;
    repeat (3) @(negedge clk);
    check(directOut == 1'b0, "R1 reset direct", directOut, 0);
    check(delayedOut == 1'b0, "R6 reset delayed", delayedOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: zero strap gives a plain splitter.
    lineReset(5'd0);
    sendBits(5, "R7 zero strap");

    // R10 and R4: one-LED delay; bit 24 blocked, bit 25 passes.
    lineReset(5'd1);
    sendBits(30, "R4 R10 strap 1");

    // R2 and R10: three-LED delay.
    lineReset(5'd3);
    sendBits(80, "R2 R10 strap 3");

    // R5: a new frame with no line reset keeps passing.
    idleOnly();
    sendBits(10, "R5 enable held");

    // R3: line reset clears the enable for a nonzero strap.
    lineReset(5'd2);
    sendBits(5, "R3 cleared by line reset");

    // R9: partial count dropped by a mid-frame idle pulse.
    lineReset(5'd2);
    sendBits(30, "R9 before pulse");
    idleOnly();
    sendBits(55, "R9 recount");

    // R10: largest delay.
    lineReset(5'd31);
    sendBits(31 * 24 + 4, "R10 strap 31");

    // R8: strap lowered below the count, then run past 32 LEDs.
    lineReset(5'd31);
    sendBits(72, "R8 before change");
    delayStrap = 5'd2;
    sendBits(36 * 24 - 72, "R8 saturation");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R2 all bits seen", expQ.size(), 0);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule